// File: doc/BRIEF.md
# Reconfigurable Four-Lane Multiply-Add Slice

This block is an arithmetic slice with four signed multipliers, each followed by two levels of adders, a subtractor and accumulators. A two-bit mode select sets what the adder levels do. The slice can add all four products into one result. It can form a complex product. It can pass the four products out unchanged. It can also act as two independent multiply-accumulate channels. All of this runs on a single clock.

The operand registers come in two banks, one for data and one for coefficients. Each bank is set on its own to load all four lanes at once or to act as a tap delay line. In the tap delay line, lane 0 takes the new value and every other lane takes the value of the lane below it. A filter can therefore keep shifting its samples while its coefficients are replaced all at once.

A build-time parameter inserts an optional register stage between the multipliers and the adders. This trades one cycle of latency for a shorter logic path. A valid flag follows whichever latency is chosen.

Top module: `mac4_slice`

## Requirements
- R1: While reset is asserted and until the first accepted input has passed through the slice, `res_valid` is 0, every result lane is 0, and the operand registers and both accumulators are 0. Reset is asynchronous and active-low, and its release is synchronised internally over two clock edges.
- R2: Lane k of `data_in` or `coef_in` occupies bits [18k+17:18k], and each lane is 18-bit two's complement. When `in_valid` is 1 and the shift control of a bank is 0, every lane of that bank loads from the matching input lane. Both banks can load this way at once.
- R3: When `in_valid` is 1 and `data_shift` is 1, the data bank acts as a delay line: lane 0 takes `data_in` lane 0 and lane k takes the old lane k-1. The coefficient bank can load in parallel in the same cycle.
- R4: With both `data_shift` and `coef_shift` at 1, both banks shift as delay lines in the same cycle.
- R5: When `in_valid` is 0, both banks keep their contents, no result is produced, and the result lanes hold their last value.
- R6: `mode`=0 (sum): result lane 0 is p0+p1+p2+p3, sign-extended, and lanes 1 to 3 are 0. Here pk is data lane k times coefficient lane k. Result lane k occupies bits [52k+51:52k].
- R7: `mode`=1 (complex): lane 0 is p0-p1 and lane 1 is p2+p3, and lanes 2 and 3 are 0. With data lanes {ar,ai,ar,ai} and coefficient lanes {br,bi,bi,br} (lane 0 first), this gives ar*br-ai*bi and ar*bi+ai*br.
- R8: `mode`=2 (independent): result lane k is pk, sign-extended to 52 bits.
- R9: `mode`=3 (two accumulators): accumulator A adds p0+p1 and accumulator B adds p2+p3. Result lanes 0 and 1 show the updated A and B, and lanes 2 and 3 are 0. The accumulators change only on valid results in this mode.
- R10: In `mode`=3, an input taken with `acc_clr`=1 loads each accumulator with its new pair sum and discards the old total.
- R11: An input accepted at clock edge k gives its result and `res_valid`=1 after edge k+2 when the pipeline stage is enabled (PIPE=1), and after edge k+1 when it is bypassed. `mode` and `acc_clr` are sampled together with the operands.
- R12: Products are exact at the extremes of the range: -131072 times -131072 is +17179869184, and every mode carries that value with the correct sign.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Accepts the operands, mode and clear in this cycle |
| data_shift | input | 1 | 1: data bank shifts as a delay line; 0: parallel load |
| coef_shift | input | 1 | 1: coefficient bank shifts as a delay line; 0: parallel load |
| mode | input | 2 | 0 sum, 1 complex, 2 independent, 3 dual accumulate |
| acc_clr | input | 1 | Loads the accumulators with the new sums instead of adding |
| data_in | input | 72 | Four 18-bit data lanes |
| coef_in | input | 72 | Four 18-bit coefficient lanes |
| res_valid | output | 1 | A result is present on `res` |
| res | output | 208 | Four 52-bit signed result lanes |

## Verification
The assertions assume that no accumulated total ever exceeds 52 signed bits. The stimulus keeps each multiply-accumulate run short, so the totals stay far below that limit even with extreme operands. They also assume that `in_valid` is held at 0 until the internal reset release has finished, and the bench waits for that before it drives any input. Random operands favour the most negative and most positive 18-bit values, and the bench compares two copies of the slice, one with the pipeline stage and one without, against one reference model.

// File: rtl/mac4_pkg.sv
package mac4_pkg;
  localparam int LANES = 4;

  typedef enum logic [1:0] {
    MODE_SUM4  = 2'd0,
    MODE_CPLX  = 2'd1,
    MODE_INDEP = 2'd2,
    MODE_MAC2  = 2'd3
  } mode_e;
endpackage

// File: rtl/mac4_opreg.sv
module mac4_opreg #(
  parameter int W = 18,
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         shift,
  input  logic [N*W-1:0] din,
  output logic [N*W-1:0] q
);
  logic [W-1:0] q_r  [N];
  logic [W-1:0] q_nx [N];

  for (genvar g = 0; g < N; g++) begin : g_lane
    if (g == 0) begin : g_head
      always_comb begin
        if (en) q_nx[g] = din[W-1:0];
        else    q_nx[g] = q_r[g];
      end
    end else begin : g_tail
      always_comb begin
        if (!en)       q_nx[g] = q_r[g];
        else if (shift) q_nx[g] = q_r[g-1];
        else           q_nx[g] = din[g*W +: W];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q_r[g] <= '0;
      else        q_r[g] <= q_nx[g];
    end

    assign q[g*W +: W] = q_r[g];
  end

  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !shift) |=> (q == $past(din)));

  p_shift_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && shift) |=> (q[W-1:0] == $past(din[W-1:0]) &&
                       q[N*W-1:W] == $past(q[(N-1)*W-1:0])));

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(q));
endmodule

// File: rtl/mac4_mulstage.sv
module mac4_mulstage #(
  parameter int W    = 18,
  parameter int N    = 4,
  parameter int CW   = 3,
  parameter bit PIPE = 1'b1,
  localparam int PW  = 2 * W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            vin,
  input  logic [CW-1:0]   ctl_in,
  input  logic [N*W-1:0]  a,
  input  logic [N*W-1:0]  b,
  output logic            vout,
  output logic [CW-1:0]   ctl_out,
  output logic [N*PW-1:0] prod
);
  logic [N*PW-1:0] raw;

  for (genvar g = 0; g < N; g++) begin : g_mul
    logic signed [PW-1:0] pg;
    assign pg = $signed(a[g*W +: W]) * $signed(b[g*W +: W]);
    assign raw[g*PW +: PW] = pg;
  end

  if (PIPE) begin : g_pipe
    logic [N*PW-1:0] prod_q, prod_nx;
    logic [CW-1:0]   ctl_q, ctl_nx;
    logic            v_q;

    always_comb begin
      prod_nx = vin ? raw : prod_q;
      ctl_nx  = vin ? ctl_in : ctl_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prod_q <= '0;
        ctl_q  <= '0;
        v_q    <= 1'b0;
      end else begin
        prod_q <= prod_nx;
        ctl_q  <= ctl_nx;
        v_q    <= vin;
      end
    end

    assign prod    = prod_q;
    assign ctl_out = ctl_q;
    assign vout    = v_q;

    p_pipe_follow_r11: assert property (@(posedge clk) disable iff (!rst_n)
      vin |=> vout);
    p_pipe_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !vin |=> !vout);
  end else begin : g_bypass
    assign prod    = raw;
    assign ctl_out = ctl_in;
    assign vout    = vin;
  end

  p_minneg_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (a[W-1:0] == {1'b1, {(W-1){1'b0}}} && b[W-1:0] == {1'b1, {(W-1){1'b0}}})
      |-> (raw[PW-1:0] == {2'b01, {(PW-2){1'b0}}}));
endmodule

// File: rtl/mac4_combine.sv
module mac4_combine
  import mac4_pkg::*;
#(
  parameter int PW = 36,
  parameter int AW = 52,
  localparam int L1W = PW + 1,
  localparam int L2W = PW + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vin,
  input  logic [1:0]        mode,
  input  logic              clr,
  input  logic [LANES*PW-1:0] prod,
  output logic              res_valid,
  output logic [LANES*AW-1:0] res
);
  mode_e md;
  logic signed [PW-1:0]  p [LANES];
  logic signed [L1W-1:0] s01, s23;
  logic signed [L2W-1:0] s_all;
  logic signed [AW-1:0]  e01, e23, eall;
  logic signed [AW-1:0]  acc0_q, acc1_q, acc0_nx, acc1_nx;
  logic signed [AW-1:0]  r_q [LANES];
  logic signed [AW-1:0]  r_nx [LANES];
  logic                  v_q;

  assign md = mode_e'(mode);

  for (genvar g = 0; g < LANES; g++) begin : g_unpack
    assign p[g] = prod[g*PW +: PW];
    assign res[g*AW +: AW] = r_q[g];
  end

  // first level: pair add / subtract
  always_comb begin
    if (md == MODE_CPLX) s01 = {p[0][PW-1], p[0]} - {p[1][PW-1], p[1]};
    else                 s01 = {p[0][PW-1], p[0]} + {p[1][PW-1], p[1]};
    s23   = {p[2][PW-1], p[2]} + {p[3][PW-1], p[3]};
    s_all = {s01[L1W-1], s01} + {s23[L1W-1], s23};
    e01   = {{(AW-L1W){s01[L1W-1]}}, s01};
    e23   = {{(AW-L1W){s23[L1W-1]}}, s23};
    eall  = {{(AW-L2W){s_all[L2W-1]}}, s_all};
  end

  // second level: accumulators
  always_comb begin
    acc0_nx = acc0_q;
    acc1_nx = acc1_q;
    if (vin && md == MODE_MAC2) begin
      acc0_nx = (clr ? '0 : acc0_q) + e01;
      acc1_nx = (clr ? '0 : acc1_q) + e23;
    end
  end

  always_comb begin
    for (int k = 0; k < LANES; k++) r_nx[k] = r_q[k];
    if (vin) begin
      for (int k = 0; k < LANES; k++) r_nx[k] = '0;
      unique case (md)
        MODE_SUM4: r_nx[0] = eall;
        MODE_CPLX: begin
          r_nx[0] = e01;
          r_nx[1] = e23;
        end
        MODE_INDEP: begin
          for (int k = 0; k < LANES; k++)
            r_nx[k] = {{(AW-PW){p[k][PW-1]}}, p[k]};
        end
        MODE_MAC2: begin
          r_nx[0] = acc0_nx;
          r_nx[1] = acc1_nx;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc0_q <= '0;
      acc1_q <= '0;
      v_q    <= 1'b0;
      for (int k = 0; k < LANES; k++) r_q[k] <= '0;
    end else begin
      acc0_q <= acc0_nx;
      acc1_q <= acc1_nx;
      v_q    <= vin;
      for (int k = 0; k < LANES; k++) r_q[k] <= r_nx[k];
    end
  end

  assign res_valid = v_q;

  p_acc_show_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (vin && md == MODE_MAC2) |=> (r_q[0] == acc0_q && r_q[1] == acc1_q &&
                                  r_q[2] == '0 && r_q[3] == '0));

  p_acc_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(vin && md == MODE_MAC2) |=> ($stable(acc0_q) && $stable(acc1_q)));

  p_sum_lanes_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (vin && md == MODE_SUM4) |=> (r_q[1] == '0 && r_q[2] == '0 && r_q[3] == '0));

  p_hold_out_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !vin |=> (!res_valid && $stable(res)));
endmodule

// File: rtl/mac4_slice.sv
module mac4_slice
  import mac4_pkg::*;
#(
  parameter int W    = 18,
  parameter int AW   = 52,
  parameter bit PIPE = 1'b1,
  localparam int PW  = 2 * W,
  localparam int CW  = 3,
  localparam int LAT = PIPE ? 2 : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic                 data_shift,
  input  logic                 coef_shift,
  input  logic [1:0]           mode,
  input  logic                 acc_clr,
  input  logic [LANES*W-1:0]   data_in,
  input  logic [LANES*W-1:0]   coef_in,
  output logic                 res_valid,
  output logic [LANES*AW-1:0]  res
);
  logic       rs0, rs1, rst_n_s;
  logic       v_op, v_op_nx;
  logic [CW-1:0] ctl_op, ctl_op_nx, ctl_mul;
  logic       v_mul;
  logic [LANES*W-1:0]  d_q, c_q;
  logic [LANES*PW-1:0] prod;
  logic [1:0] since_rst, since_rst_nx;

  // reset released in step with the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs0 <= 1'b0;
      rs1 <= 1'b0;
    end else begin
      rs0 <= 1'b1;
      rs1 <= rs0;
    end
  end
  assign rst_n_s = rs1;

  always_comb begin
    v_op_nx   = in_valid;
    ctl_op_nx = in_valid ? {acc_clr, mode} : ctl_op;
    since_rst_nx = (since_rst == 2'd3) ? since_rst : since_rst + 2'd1;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      v_op      <= 1'b0;
      ctl_op    <= '0;
      since_rst <= '0;
    end else begin
      v_op      <= v_op_nx;
      ctl_op    <= ctl_op_nx;
      since_rst <= since_rst_nx;
    end
  end

  mac4_opreg #(.W(W), .N(LANES)) u_dbank (
    .clk(clk), .rst_n(rst_n_s), .en(in_valid), .shift(data_shift),
    .din(data_in), .q(d_q)
  );

  mac4_opreg #(.W(W), .N(LANES)) u_cbank (
    .clk(clk), .rst_n(rst_n_s), .en(in_valid), .shift(coef_shift),
    .din(coef_in), .q(c_q)
  );

  mac4_mulstage #(.W(W), .N(LANES), .CW(CW), .PIPE(PIPE)) u_mul (
    .clk(clk), .rst_n(rst_n_s), .vin(v_op), .ctl_in(ctl_op),
    .a(d_q), .b(c_q), .vout(v_mul), .ctl_out(ctl_mul), .prod(prod)
  );

  mac4_combine #(.PW(PW), .AW(AW)) u_comb (
    .clk(clk), .rst_n(rst_n_s), .vin(v_mul), .mode(ctl_mul[1:0]),
    .clr(ctl_mul[2]), .prod(prod), .res_valid(res_valid), .res(res)
  );

  p_latency_r11: assert property (@(posedge clk) disable iff (!rst_n_s)
    (since_rst >= 2'(LAT)) |-> (res_valid == $past(in_valid, LAT + 1)));
endmodule

// File: tb/mac4_slice_test.sv
module mac4_slice_test;
  localparam int W = 18;
  localparam int N = 4;
  localparam int AW = 52;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, in_valid, data_shift, coef_shift, acc_clr;
  logic [1:0] mode;
  logic [N*W-1:0] data_in, coef_in;
  logic [N*AW-1:0] res_p, res_b;
  logic v_p, v_b;

  mac4_slice #(.PIPE(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .data_shift(data_shift),
    .coef_shift(coef_shift), .mode(mode), .acc_clr(acc_clr),
    .data_in(data_in), .coef_in(coef_in), .res_valid(v_p), .res(res_p));

  mac4_slice #(.PIPE(1'b0)) uut_byp (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .data_shift(data_shift),
    .coef_shift(coef_shift), .mode(mode), .acc_clr(acc_clr),
    .data_in(data_in), .coef_in(coef_in), .res_valid(v_b), .res(res_b));

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  string tag = "R1";

  longint md[N], mc[N];
  longint macc0 = 0, macc1 = 0;
  bit     qv_p[8], qv_b[8];
  longint qr_p[8][N], qr_b[8][N];
  string  qt_p[8], qt_b[8];
  longint last_p[N], last_b[N];

  function automatic longint sx(input logic [W-1:0] x);
    return longint'($signed(x));
  endfunction

  function automatic logic [W-1:0] rop();
    logic [W-1:0] v;
    int r;
    r = int'($urandom % 8);
    v = W'($urandom);
    if (r == 0) v = {1'b1, {(W-1){1'b0}}};
    if (r == 1) v = {1'b0, {(W-1){1'b1}}};
    return v;
  endfunction

  function automatic logic [N*W-1:0] rvec();
    logic [N*W-1:0] v;
    for (int k = 0; k < N; k++) v[k*W +: W] = rop();
    return v;
  endfunction

  task automatic cmp(input bit pipe);
    int s;
    bit ev;
    longint ex[N];
    longint act;
    bit bad;
    string t;
    s = cyc % 8;
    ev = pipe ? qv_p[s] : qv_b[s];
    t = ev ? (pipe ? qt_p[s] : qt_b[s]) : "R11";
    for (int k = 0; k < N; k++) begin
      if (ev) begin
        if (pipe) last_p[k] = qr_p[s][k];
        else      last_b[k] = qr_b[s][k];
      end
      ex[k] = pipe ? last_p[k] : last_b[k];
    end
    checks++;
    bad = ((pipe ? v_p : v_b) != ev);
    for (int k = 0; k < N; k++) begin
      act = longint'($signed(pipe ? res_p[k*AW +: AW] : res_b[k*AW +: AW]));
      if (act != ex[k]) begin
        bad = 1'b1;
        $display("FAIL %s pipe=%0d cyc=%0d lane%0d actual=%0d expected=%0d",
                 t, pipe, cyc, k, act, ex[k]);
      end
    end
    if ((pipe ? v_p : v_b) != ev)
      $display("FAIL %s pipe=%0d cyc=%0d valid actual=%0b expected=%0b",
               t, pipe, cyc, (pipe ? v_p : v_b), ev);
    if (bad) errors++;
    if (pipe) qv_p[s] = 1'b0;
    else      qv_b[s] = 1'b0;
  endtask

  task automatic step();
    @(posedge clk);
    cyc++;
    @(negedge clk);
    cmp(1'b1);
    cmp(1'b0);
  endtask

  task automatic drive(input bit v, input bit ds, input bit cs, input logic [1:0] m,
                       input bit clr, input logic [N*W-1:0] d, input logic [N*W-1:0] c);
    longint p[N];
    longint e[N];
    int sp, sb;
    in_valid = v; data_shift = ds; coef_shift = cs; mode = m; acc_clr = clr;
    data_in = d; coef_in = c;
    if (v) begin
      if (ds) begin
        for (int k = N-1; k > 0; k--) md[k] = md[k-1];
        md[0] = sx(d[W-1:0]);
      end else for (int k = 0; k < N; k++) md[k] = sx(d[k*W +: W]);
      if (cs) begin
        for (int k = N-1; k > 0; k--) mc[k] = mc[k-1];
        mc[0] = sx(c[W-1:0]);
      end else for (int k = 0; k < N; k++) mc[k] = sx(c[k*W +: W]);
      for (int k = 0; k < N; k++) begin
        p[k] = md[k] * mc[k];
        e[k] = 0;
      end
      case (m)
        2'd0: e[0] = p[0] + p[1] + p[2] + p[3];
        2'd1: begin e[0] = p[0] - p[1]; e[1] = p[2] + p[3]; end
        2'd2: for (int k = 0; k < N; k++) e[k] = p[k];
        default: begin
          macc0 = (clr ? 0 : macc0) + p[0] + p[1];
          macc1 = (clr ? 0 : macc1) + p[2] + p[3];
          e[0] = macc0; e[1] = macc1;
        end
      endcase
      sp = (cyc + 3) % 8;
      sb = (cyc + 2) % 8;
      qv_p[sp] = 1'b1; qv_b[sb] = 1'b1;
      qt_p[sp] = tag;  qt_b[sb] = tag;
      for (int k = 0; k < N; k++) begin
        qr_p[sp][k] = e[k];
        qr_b[sb][k] = e[k];
      end
    end
    step();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(1'b0, 1'b0, 1'b0, 2'd0, 1'b0, '0, '0);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog expired cyc=%0d actual=running expected=done", cyc);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [W-1:0] ar, ai, br, bi, mn;
    for (int k = 0; k < N; k++) begin
      md[k] = 0; mc[k] = 0; last_p[k] = 0; last_b[k] = 0;
    end
    for (int s = 0; s < 8; s++) begin qv_p[s] = 1'b0; qv_b[s] = 1'b0; end
    rst_n = 1'b0;
    in_valid = 1'b0; data_shift = 1'b0; coef_shift = 1'b0; mode = 2'd0;
    acc_clr = 1'b0; data_in = '0; coef_in = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: outputs cleared across the reset release window
    tag = "R1";
    for (int i = 0; i < 4; i++) step();

    tag = "R2"; // parallel load, sum mode (R6)
    for (int i = 0; i < 12; i++) drive(1'b1, 1'b0, 1'b0, 2'd0, 1'b0, rvec(), rvec());
    tag = "R6";
    for (int i = 0; i < 12; i++) drive(1'b1, 1'b0, 1'b0, 2'd0, 1'b0, rvec(), rvec());

    tag = "R12"; // most negative operands in every lane
    mn = {1'b1, {(W-1){1'b0}}};
    drive(1'b1, 1'b0, 1'b0, 2'd0, 1'b0, {N{mn}}, {N{mn}});
    drive(1'b1, 1'b0, 1'b0, 2'd2, 1'b0, {N{mn}}, {N{mn}});
    drive(1'b1, 1'b0, 1'b0, 2'd1, 1'b0, {N{mn}}, {N{mn}});
    drive(1'b1, 1'b0, 1'b0, 2'd3, 1'b1, {N{mn}}, {N{mn}});

    tag = "R7"; // complex product
    for (int i = 0; i < 20; i++) begin
      ar = rop(); ai = rop(); br = rop(); bi = rop();
      drive(1'b1, 1'b0, 1'b0, 2'd1, 1'b0, {ai, ar, ai, ar}, {br, bi, bi, br});
    end

    tag = "R3"; // data delay line, coefficients loaded in parallel, independent (R8)
    for (int i = 0; i < 20; i++) drive(1'b1, 1'b1, 1'b0, 2'd2, 1'b0, rvec(), rvec());
    tag = "R8";
    for (int i = 0; i < 8; i++) drive(1'b1, 1'b0, 1'b0, 2'd2, 1'b0, rvec(), rvec());

    tag = "R4"; // both banks shift
    for (int i = 0; i < 20; i++) drive(1'b1, 1'b1, 1'b1, 2'd2, 1'b0, rvec(), rvec());

    tag = "R5"; // gaps in the input stream with mixed load/shift
    for (int i = 0; i < 40; i++)
      drive(1'(($urandom % 3) != 0), 1'($urandom), 1'($urandom),
            2'($urandom), 1'b1, rvec(), rvec());

    tag = "R9"; // two accumulators
    drive(1'b1, 1'b0, 1'b0, 2'd3, 1'b1, rvec(), rvec());
    for (int i = 0; i < 15; i++) drive(1'b1, 1'b0, 1'b1, 2'd3, 1'b0, rvec(), rvec());
    for (int i = 0; i < 5; i++) drive(1'b1, 1'b0, 1'b0, 2'd2, 1'b0, rvec(), rvec());
    idle(3);
    for (int i = 0; i < 5; i++) drive(1'b1, 1'b0, 1'b0, 2'd3, 1'b0, rvec(), rvec());

    tag = "R10"; // clear in the middle of a run
    for (int i = 0; i < 16; i++)
      drive(1'b1, 1'b0, 1'b0, 2'd3, 1'(i % 5 == 2), rvec(), rvec());

    tag = "R11"; // isolated pulses expose latency
    for (int i = 0; i < 6; i++) begin
      drive(1'b1, 1'b0, 1'b0, 2'(i % 3), 1'b0, rvec(), rvec());
      idle(3);
    end
    idle(4);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule